// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the target-side logic that answers a host polling the SMBus alert response address. It watches the open-drain clock and data lines and drives the data line only through a pull-down enable. When the host sends address `0001100` with the read bit set and this device has an alert pending, the block acknowledges. It then returns its own 7-bit slave address, which comes from the address-select pins, as a single receive-byte data byte.

Several devices may raise alerts at the same time and all of them answer together. The block therefore arbitrates bit by bit on the returned byte, and the device with the lowest address wins. A device that loses arbitration lets go of the bus and keeps its alert. Only a device that sends the whole byte, sees the host NACK it and then sees a STOP raises a one-cycle clear pulse to its alert logic.

Both bus lines are brought into the block clock domain through synchronizer stages. Every decision is made from the synchronized SCL edges. There is no data stream at the edge of the block, so all pins are plain levels and pulses.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, `sda_pull` and `alert_clear` are both low.
- R2: A read to address 0001100 (address byte 0x19) while `alert_pending` is high is acknowledged: SDA is pulled low for the whole ninth SCL pulse.
- R3: A read to 0001100 with no alert pending, a write to 0001100, or any other address is not acknowledged, and the block never pulls SDA during that transfer.
- R4: After the acknowledge, the block sends the byte {`dev_addr`[6:0], 1} MSB first, changing SDA only while SCL is low.
- R5: If the block releases SDA for a 1 but samples SDA low while SCL is high, it loses arbitration. It then keeps SDA released for the rest of the transfer and does not raise `alert_clear`.
- R6: After a byte is sent without losing arbitration and the host NACKs it, `alert_clear` is high for exactly one clock cycle once the following STOP is detected.
- R7: If the host ACKs the returned byte, or a new START arrives in place of the STOP, no clear pulse is raised.
- R8: A STOP or START on the bus returns the block to its idle or address-receiving state at any point. A STOP releases SDA. A START begins a fresh address byte, so an interrupted transfer has no effect on the next one.
- R9: `sda_pull` rises only in the cycle after a falling SCL edge has been detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| dev_addr | input | 7 | Own slave address from the address-select pins |
| alert_pending | input | 1 | High while this device has an unserviced alert |
| sda_pull | output | 1 | High pulls SDA low (open-drain enable) |
| alert_clear | output | 1 | One-cycle pulse: this alert has been serviced |

## Verification
Random transfers mix random own and rival addresses, the alert state of each device, the host ACK or NACK, and correct versus wrong addresses and direction bits. They tell apart an answer from silence, a won byte from a lost one, and a cleared alert from a kept one. A rival model with its own arbitration sits on the same wired-AND line, so the byte the host reads must be the lower of the two addresses. Directed cases cover a lost and a won arbitration, a host ACK on the data byte, a STOP and a repeated START in the middle of the address, and a write to the alert address.

// File: rtl/smba_pkg.sv
package smba_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DECIDE,
    ST_ACK,
    ST_SEND,
    ST_HOST_ACK,
    ST_WAIT_STOP,
    ST_DONE
  } resp_state_e;
endpackage

// File: rtl/smba_bus_sampler.sv
module smba_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_rise,
  output logic sda_fall
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign sda_rise = sda_s & ~sda_q;
  assign sda_fall = ~sda_s & sda_q;
endmodule

// File: rtl/smba_cond_detect.sv
module smba_cond_detect (
  input  logic scl_s,
  input  logic scl_rise,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_steady_high;
  assign scl_steady_high = scl_s & ~scl_rise;
  assign start_det = scl_steady_high & sda_fall;
  assign stop_det  = scl_steady_high & sda_rise;
endmodule

// File: rtl/smba_resp_fsm.sv
module smba_resp_fsm
  import smba_pkg::*;
#(
  parameter int         ADDR_W   = 7,
  parameter logic [6:0] ARA_ADDR = 7'b0001100,
  parameter logic       LSB_FILL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              alert_pending,
  output logic              sda_pull,
  output logic              alert_clear
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] ARA_READ = {ARA_ADDR[ADDR_W-1:0], 1'b1};

  resp_state_e       st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              hit;
  logic [BYTE_W-1:0] rx_next;

  assign rx_next = {rx_sh[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      hit         <= 1'b0;
      sda_pull    <= 1'b0;
      alert_clear <= 1'b0;
    end else begin
      alert_clear <= 1'b0;
      if (stop_det) begin
        alert_clear <= (st == ST_WAIT_STOP);
        st          <= ST_IDLE;
        sda_pull    <= 1'b0;
      end else if (start_det) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sh <= rx_next;
              cnt   <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                hit <= (rx_next == ARA_READ);
                st  <= ST_DECIDE;
              end
            end
          end
          ST_DECIDE: begin
            if (scl_fall) begin
              if (hit && alert_pending) begin
                sda_pull <= 1'b1;
                tx_sh    <= {dev_addr, LSB_FILL};
                st       <= ST_ACK;
              end else begin
                st <= ST_DONE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_pull <= ~tx_sh[BYTE_W-1];
              cnt      <= '0;
              st       <= ST_SEND;
            end
          end
          ST_SEND: begin
            if (scl_rise && tx_sh[BYTE_W-1] && !sda_s) begin
              sda_pull <= 1'b0;
              st       <= ST_DONE;
            end else if (scl_fall) begin
              cnt   <= cnt + 1'b1;
              tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
              if (cnt == LAST_BIT) begin
                sda_pull <= 1'b0;
                st       <= ST_HOST_ACK;
              end else begin
                sda_pull <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_HOST_ACK: begin
            if (scl_rise) st <= sda_s ? ST_WAIT_STOP : ST_DONE;
          end
          ST_WAIT_STOP: ;
          ST_DONE: ;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
  parameter int         ADDR_W      = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ARA_ADDR    = 7'b0001100,
  parameter logic       LSB_FILL    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              alert_pending,
  output logic              sda_pull,
  output logic              alert_clear
);
  logic scl_s, sda_s, scl_rise, scl_fall, sda_rise, sda_fall;
  logic start_det, stop_det;

  smba_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_rise(sda_rise), .sda_fall(sda_fall)
  );

  smba_cond_detect u_cond (
    .scl_s(scl_s), .scl_rise(scl_rise), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smba_resp_fsm #(.ADDR_W(ADDR_W), .ARA_ADDR(ARA_ADDR), .LSB_FILL(LSB_FILL)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .dev_addr(dev_addr),
    .alert_pending(alert_pending), .sda_pull(sda_pull), .alert_clear(alert_clear)
  );
endmodule

// File: rtl/smba_chk.sv
module smba_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic sda_pull,
  input logic alert_clear
);
  // R6
  clear_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clear |=> !alert_clear);
  // R6
  clear_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clear |-> $past(stop_det));
  // R9
  pull_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));
  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!sda_pull && !alert_clear));
endmodule

bind smb_alert_responder smba_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .sda_pull(sda_pull), .alert_clear(alert_clear)
);

// File: tb/smb_alert_responder_tb.sv
module smb_alert_responder_tb;
  localparam int Q = 10;
  localparam logic [6:0] ARA = 7'b0001100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_pull = 1'b0;
  logic r_pull = 1'b0;
  logic [6:0] dev_addr = 7'h4C;
  logic alert_pending = 1'b0;
  logic sda_pull, alert_clear;
  logic sda_line;
  int errors = 0;
  int checks = 0;
  int clr_cnt = 0;
  bit oe_seen = 0;

  always #2 clk = ~clk;
  assign sda_line = !(m_pull || r_pull || sda_pull);

  smb_alert_responder u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_addr(dev_addr), .alert_pending(alert_pending),
    .sda_pull(sda_pull), .alert_clear(alert_clear)
  );

  always @(negedge clk) begin
    if (alert_clear) clr_cnt++;
    if (sda_pull) oe_seen = 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin
      w(Q); m_pull = 0; w(Q); scl = 1; w(Q);
    end
    m_pull = 0; w(Q); m_pull = 1; w(2*Q); scl = 0;
  endtask

  task automatic bus_stop();
    w(Q); r_pull = 0; m_pull = 1; w(Q); scl = 1; w(2*Q); m_pull = 0; w(2*Q);
  endtask

  task automatic put_bit(input logic b);
    w(Q); m_pull = ~b; w(Q); scl = 1; w(2*Q); scl = 0;
  endtask

  task automatic get_bit(input logic rdrive, output logic b);
    m_pull = 0; w(Q); r_pull = rdrive; w(Q); scl = 1; w(Q); b = sda_line; w(Q); scl = 0;
  endtask

  // Full alert-response style transfer with an optional rival responder.
  task automatic xfer(input logic [6:0] a, input logic rw, input logic host_ack,
                      input logic rival_en, input logic [6:0] rival_a,
                      output logic ackb, output logic [7:0] rb);
    logic [7:0] rbyte;
    logic rival_alive;
    logic b;
    rbyte = {rival_a, 1'b1};
    rival_alive = rival_en && a == ARA && rw;
    bus_start();
    for (int i = 7; i >= 1; i--) put_bit(a[i-1]);
    put_bit(rw);
    get_bit(rival_alive, ackb);
    rb = 8'h00;
    if (!ackb) begin
      for (int i = 7; i >= 0; i--) begin
        get_bit(rival_alive && !rbyte[i], b);
        if (rival_alive && rbyte[i] && !b) rival_alive = 0;
        rb = {rb[6:0], b};
      end
      w(Q); r_pull = 0; m_pull = host_ack; w(Q); scl = 1; w(2*Q); scl = 0;
    end
    r_pull = 0;
    bus_stop();
  endtask

  function automatic logic [7:0] exp_byte(input logic mine, input logic rival,
                                          input logic [6:0] d, input logic [6:0] r);
    logic [6:0] v;
    if (mine && rival) v = (d < r) ? d : r;
    else if (mine) v = d;
    else v = r;
    return {v, 1'b1};
  endfunction

  task automatic run_case(input string tag, input logic [6:0] a, input logic rw,
                          input logic pend, input logic host_ack,
                          input logic rival_en, input logic [6:0] rival_a);
    logic ackb;
    logic [7:0] rb;
    logic addressed, mine, exp_clr;
    int c0;
    alert_pending = pend;
    addressed = (a == ARA) && rw;
    mine = addressed && pend;
    exp_clr = mine && (!rival_en || dev_addr < rival_a) && !host_ack;
    c0 = clr_cnt;
    oe_seen = 0;
    xfer(a, rw, host_ack, rival_en, rival_a, ackb, rb);
    w(4);
    check({tag, " R2/R3 ack"}, int'(ackb), int'(!(mine || (addressed && rival_en))));
    if (!ackb) check({tag, " R4/R5 byte"}, int'(rb), int'(exp_byte(mine, rival_en, dev_addr, rival_a)));
    if (!mine) check({tag, " R3 no pull"}, int'(oe_seen), 0);
    check({tag, " R6/R7 clear"}, clr_cnt - c0, int'(exp_clr));
    check({tag, " R8 idle release"}, int'(sda_pull), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic b;
    void'($urandom(32'd1234));
    w(5);
    check("R1 reset pull", int'(sda_pull), 0);
    check("R1 reset clear", int'(alert_clear), 0);
    rst_n = 1;
    w(5);
    // R2 R4 R6: lone responder
    run_case("lone", ARA, 1, 1, 0, 0, 7'h00);
    // R3: no alert, write, wrong address
    run_case("nopend", ARA, 1, 0, 0, 0, 7'h00);
    run_case("write", ARA, 0, 1, 0, 0, 7'h00);
    run_case("other", 7'h0D, 1, 1, 0, 0, 7'h00);
    // R5: rival lower wins, then rival higher loses
    run_case("lost", ARA, 1, 1, 0, 1, 7'h48);
    run_case("won", ARA, 1, 1, 0, 1, 7'h4D);
    // R7: host acknowledges the data byte
    run_case("hostack", ARA, 1, 1, 1, 0, 7'h00);
    // R8: STOP in the middle of the address byte
    bus_start(); put_bit(0); put_bit(0); put_bit(1); bus_stop();
    run_case("afterstop", ARA, 1, 1, 0, 0, 7'h00);
    // R8: repeated START in the middle of the address byte
    bus_start(); put_bit(1); put_bit(1); put_bit(0);
    run_case("restart", ARA, 1, 1, 0, 0, 7'h00);
    // R7: START instead of STOP after NACK gives no clear
    begin
      int c0;
      c0 = clr_cnt;
      alert_pending = 1;
      bus_start();
      for (int i = 6; i >= 0; i--) put_bit(ARA[i]);
      put_bit(1);
      get_bit(0, b);
      for (int i = 0; i < 8; i++) get_bit(0, b);
      put_bit(1);
      run_case("rs_follow", 7'h22, 0, 1, 0, 0, 7'h00);
      check("R7 restart no clear", clr_cnt - c0, 0);
    end
    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [6:0] d, r, a;
      logic rival_en, pend, hack, rw;
      d = 7'($urandom);
      r = 7'($urandom);
      if (r == d) r = d ^ 7'h01;
      rival_en = 1'($urandom);
      pend = ($urandom % 4) != 0;
      hack = ($urandom % 5) == 0;
      rw = ($urandom % 6) != 0;
      a = (($urandom % 5) == 0) ? 7'($urandom) : ARA;
      dev_addr = d;
      run_case("rand", a, rw, pend, hack, rival_en, r);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule